// File: doc/BRIEF.md
# Transmit Power Ramp Shaper

This block turns a small programmable table of power-amplifier setting words into the word presented to the amplifier for each fraction of a symbol. A saturating index walks through the table on a step strobe that the surrounding transmitter pulses eight times per symbol. It produces a gradual rise in power when a transmission starts and a gradual fall when it ends, and it shapes the amplitude for amplitude-shift keying. In on-off keying the index is bypassed and each data bit picks one of the two lowest table entries directly.

Software loads the table through a simple write port and picks the highest entry the ramp may reach. Entering the low-power sleep state wipes every entry except the lowest one, which holds the idle power setting. The output word is registered and changes only on a step strobe, so a table write made during a transmission reaches the amplifier at the next step.

Top module: `pa_ramp_shaper`

## Requirements
- R1: After reset the output word is 0, every table entry is 0 and the ramp index is 0.
- R2: The output word and the ramp index change only at a clock edge where `step_tick` is 1.
- R3: In constant-envelope mode (`shape_mode` 2'b00 or 2'b11), a step with `tx_on`=1 raises the index by one, saturating at `max_idx`; the output becomes the table entry at the new index.
- R4: A step with `tx_on`=0 (constant-envelope or ASK mode) lowers the index by one, saturating at 0; once the index is 0 the output is table entry 0.
- R5: In ASK mode (`shape_mode` 2'b01) with `tx_on`=1, a step with `data_bit`=1 moves the index one toward `max_idx` and a step with `data_bit`=0 moves it one toward 0.
- R6: If the index lies above `max_idx` (limit lowered during a ramp), a step that moves upward lowers the index by one per step until it equals `max_idx`.
- R7: In OOK mode (`shape_mode` 2'b10) the index is forced to 0; a step outputs entry 1 when `tx_on`=1 and `data_bit`=1, otherwise entry 0.
- R8: A table write (`tbl_wr_en`=1) stores `tbl_wr_data` at `tbl_wr_idx`; a write in the same cycle as a step does not affect that step's output, only the following steps.
- R9: On the first cycle `sleep` is 1 after being 0, entries 1 to 7 are cleared and entry 0 is kept; a write to entries 1 to 7 in that cycle is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_idx | input | 3 | Table entry written |
| tbl_wr_data | input | 8 | Word written to the table |
| max_idx | input | 3 | Highest table entry the ramp may reach |
| shape_mode | input | 2 | 00/11 constant envelope, 01 ASK, 10 OOK |
| tx_on | input | 1 | Transmission active |
| sleep | input | 1 | Sleep state; rising edge clears entries 1 to 7 |
| step_tick | input | 1 | Step strobe, eight per symbol |
| data_bit | input | 1 | Current data bit |
| pa_word | output | 8 | Power-amplifier setting word |

## Verification
A table write and a ramp step can land in the same clock cycle, and the write may target the very entry the step is about to select. The bench provokes this by holding the index saturated at a limit of 3 and writing a new word to entry 3 together with the step strobe; the scoreboard expects the old word on that step and the new word on the next one. A second collision, a write to entry 2 in the cycle sleep is entered, is judged by reading entry 2 back through a ramp and expecting 0.

// File: rtl/pa_shaper_pkg.sv
// Shared types for the transmit power ramp shaper.
// Assumes: a 2-bit mode field as described in the brief.
package pa_shaper_pkg;

    typedef enum logic [1:0] {
        SHAPE_CONST     = 2'b00,
        SHAPE_ASK       = 2'b01,
        SHAPE_OOK       = 2'b10,
        SHAPE_CONST_ALT = 2'b11
    } shape_mode_e;

endpackage

// File: rtl/pa_table.sv
// Programmable table of power words with one write port and one read port.
// Entry 0 survives sleep entry; every other entry is cleared on the first
// sleep cycle, and that clear wins over a write in the same cycle.
// Assumes: ENTRIES is a power of two so every index value is a valid entry.
module pa_table #(
    parameter int ENTRIES = 8,
    parameter int WORD_W  = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              sleep,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);

    logic                           sleep_q;
    logic                           sleep_enter;
    logic [ENTRIES-1:0][WORD_W-1:0] mem;

    // Remember last cycle's sleep level to find sleep entry.
    always_ff @(posedge clk) begin
        if (!rst_n) sleep_q <= 1'b0;
        else        sleep_q <= sleep;
    end

    assign sleep_enter = sleep && !sleep_q;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic [WORD_W-1:0] ent_q;
        if (e == 0) begin : g_keep
            // Entry 0: written by software only, kept across sleep.
            always_ff @(posedge clk) begin
                if (!rst_n)                              ent_q <= '0;
                else if (wr_en && wr_idx == IDX_W'(e))   ent_q <= wr_data;
            end
        end else begin : g_clr
            // Other entries: cleared on sleep entry, else written by software.
            always_ff @(posedge clk) begin
                if (!rst_n)                              ent_q <= '0;
                else if (sleep_enter)                    ent_q <= '0;
                else if (wr_en && wr_idx == IDX_W'(e))   ent_q <= wr_data;
            end
        end
        assign mem[e] = ent_q;
    end

    assign rd_word = mem[rd_idx];

    // R9
    sleep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_enter |=> (mem[ENTRIES-1] == '0 && mem[1] == '0));

    // R9
    keep_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_enter && !(wr_en && wr_idx == '0)) |=> $stable(mem[0]));

endmodule

// File: rtl/pa_ramp_counter.sv
// Saturating ramp index. On each step it moves one toward the top limit
// when asked to rise, one toward 0 otherwise, and returns to 0 when forced.
// An index above a lowered limit walks down to the limit.
// Assumes: step_tick is a one-cycle strobe at eight times the symbol rate.
module pa_ramp_counter #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_tick,
    input  logic             go_up,
    input  logic             hold_zero,
    input  logic [IDX_W-1:0] max_idx,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] idx_next
);

    // Next index from direction, limit and saturation.
    always_comb begin
        idx_next = idx;
        if (hold_zero) begin
            idx_next = '0;
        end else if (go_up) begin
            if (idx < max_idx)      idx_next = idx + 1'b1;
            else if (idx > max_idx) idx_next = idx - 1'b1;
        end else if (idx != '0) begin
            idx_next = idx - 1'b1;
        end
    end

    // Index register, advanced only on a step.
    always_ff @(posedge clk) begin
        if (!rst_n)         idx <= '0;
        else if (step_tick) idx <= idx_next;
    end

    // R2
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_tick |=> $stable(idx));

    // R3
    rise_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_tick && go_up && !hold_zero && idx < max_idx) |=> idx == $past(idx) + 1'b1);

    // R4
    fall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_tick && !go_up && !hold_zero && idx != '0) |=> idx == $past(idx) - 1'b1);

    // R6
    above_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_tick && go_up && !hold_zero && idx > max_idx) |=> idx == $past(idx) - 1'b1);

    // R7
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_tick && hold_zero) |=> idx == '0);

endmodule

// File: rtl/pa_shape_ctrl.sv
// Mode decoder: chooses ramp direction, forces the index to 0 in on-off
// keying and picks the table entry to read for the coming step.
// Assumes: mode encodings from pa_shaper_pkg.
module pa_shape_ctrl #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [1:0]       shape_mode,
    input  logic             tx_on,
    input  logic             data_bit,
    input  logic [IDX_W-1:0] idx_next,
    output logic             go_up,
    output logic             hold_zero,
    output logic [IDX_W-1:0] sel_idx
);
    import pa_shaper_pkg::*;

    shape_mode_e mode;
    assign mode = shape_mode_e'(shape_mode);

    // Direction, forcing and entry selection per mode.
    always_comb begin
        go_up     = tx_on;
        hold_zero = 1'b0;
        sel_idx   = idx_next;
        case (mode)
            SHAPE_ASK: go_up = tx_on && data_bit;
            SHAPE_OOK: begin
                go_up     = 1'b0;
                hold_zero = 1'b1;
                sel_idx   = (tx_on && data_bit) ? IDX_W'(1) : '0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pa_ramp_shaper.sv
// Top of the transmit power ramp shaper. Registers the power word read
// from the table at the entry chosen for each step, so table writes show
// up at the following step.
// Assumes: step_tick pulses eight times per symbol; ENTRIES is a power of two.
module pa_ramp_shaper #(
    parameter int ENTRIES = 8,
    parameter int WORD_W  = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_wr_en,
    input  logic [IDX_W-1:0]  tbl_wr_idx,
    input  logic [WORD_W-1:0] tbl_wr_data,
    input  logic [IDX_W-1:0]  max_idx,
    input  logic [1:0]        shape_mode,
    input  logic              tx_on,
    input  logic              sleep,
    input  logic              step_tick,
    input  logic              data_bit,
    output logic [WORD_W-1:0] pa_word
);

    logic              go_up;
    logic              hold_zero;
    logic [IDX_W-1:0]  cnt_idx;
    logic [IDX_W-1:0]  cnt_next;
    logic [IDX_W-1:0]  sel_idx;
    logic [WORD_W-1:0] tbl_word;

    pa_shape_ctrl #(.ENTRIES(ENTRIES)) i_ctrl (
        .shape_mode (shape_mode),
        .tx_on      (tx_on),
        .data_bit   (data_bit),
        .idx_next   (cnt_next),
        .go_up      (go_up),
        .hold_zero  (hold_zero),
        .sel_idx    (sel_idx)
    );

    pa_ramp_counter #(.ENTRIES(ENTRIES)) i_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_tick  (step_tick),
        .go_up      (go_up),
        .hold_zero  (hold_zero),
        .max_idx    (max_idx),
        .idx        (cnt_idx),
        .idx_next   (cnt_next)
    );

    pa_table #(.ENTRIES(ENTRIES), .WORD_W(WORD_W)) i_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (tbl_wr_en),
        .wr_idx     (tbl_wr_idx),
        .wr_data    (tbl_wr_data),
        .sleep      (sleep),
        .rd_idx     (sel_idx),
        .rd_word    (tbl_word)
    );

    // Output word register, loaded once per step.
    always_ff @(posedge clk) begin
        if (!rst_n)         pa_word <= '0;
        else if (step_tick) pa_word <= tbl_word;
    end

    // R2
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_tick |=> $stable(pa_word));

    // R1
    reset_word_chk: assert property (@(posedge clk)
        !rst_n |=> pa_word == '0);

endmodule

// File: tb/test_pa_ramp_shaper.sv
module test_pa_ramp_shaper;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0] w;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tbl_wr_en = 1'b0;
    logic [2:0] tbl_wr_idx = '0;
    logic [7:0] tbl_wr_data = '0;
    logic [2:0] max_idx = 3'd7;
    logic [1:0] shape_mode = 2'b00;
    logic       tx_on = 1'b0;
    logic       sleep = 1'b0;
    logic       step_tick = 1'b0;
    logic       data_bit = 1'b0;
    logic [7:0] pa_word;

    int total = 0;
    int bad = 0;
    exp_t q[$];
    logic [7:0] m_tbl [8];
    int m_idx = 0;
    logic [7:0] m_word = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    pa_ramp_shaper i_pa_ramp_shaper (
        .clk(clk), .rst_n(rst_n), .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
        .tbl_wr_data(tbl_wr_data), .max_idx(max_idx), .shape_mode(shape_mode),
        .tx_on(tx_on), .sleep(sleep), .step_tick(step_tick), .data_bit(data_bit),
        .pa_word(pa_word)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected word per step and compares.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, pa_word, e.w);
        end
    end

    // Driver: one step, model computed from the requirements, optional write.
    task automatic do_step(input logic tx, input logic d, input string tag,
                           input bit wr = 0, input int widx = 0, input logic [7:0] wval = 0);
        int sel;
        bit up;
        @(negedge clk);
        tx_on = tx; data_bit = d; step_tick = 1'b1;
        if (wr) begin
            tbl_wr_en = 1'b1; tbl_wr_idx = 3'(widx); tbl_wr_data = wval;
        end
        if (shape_mode == 2'b10) begin
            m_idx = 0;
            sel = (tx && d) ? 1 : 0;
        end else begin
            up = (shape_mode == 2'b01) ? (tx && d) : tx;
            if (up) begin
                if (m_idx < int'(max_idx)) m_idx++;
                else if (m_idx > int'(max_idx)) m_idx--;
            end else if (m_idx > 0) m_idx--;
            sel = m_idx;
        end
        m_word = m_tbl[sel];
        if (wr) m_tbl[widx] = wval;
        @(posedge clk);
        #1;
        q.push_back('{m_word, tag});
        @(negedge clk);
        step_tick = 1'b0; tbl_wr_en = 1'b0;
    endtask

    task automatic do_write(input int widx, input logic [7:0] wval);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_idx = 3'(widx); tbl_wr_data = wval;
        @(negedge clk);
        tbl_wr_en = 1'b0;
        m_tbl[widx] = wval;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_tbl[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1 reset word", pa_word, 8'h00);
        rst_n = 1'b1;

        // R1: table empty after reset
        do_step(1'b1, 1'b0, "R1 table zero after reset");
        do_step(1'b0, 1'b0, "R1 back to zero");

        for (int i = 0; i < 8; i++) do_write(i, 8'h08 + 8'(i * 8'h15));
        repeat (2) @(negedge clk);
        chk("R2 no step no change", pa_word, m_word);

        // R3 ramp up, R4 ramp down
        shape_mode = 2'b00; max_idx = 3'd7;
        for (int i = 0; i < 9; i++) do_step(1'b1, 1'b0, "R3 ramp up");
        for (int i = 0; i < 9; i++) do_step(1'b0, 1'b0, "R4 ramp down");

        // R3 saturation at 3 with alternate code, R6 lowered limit
        shape_mode = 2'b11; max_idx = 3'd3;
        for (int i = 0; i < 5; i++) do_step(1'b1, 1'b1, "R3 limit 3");
        max_idx = 3'd1;
        for (int i = 0; i < 3; i++) do_step(1'b1, 1'b0, "R6 limit lowered");
        for (int i = 0; i < 2; i++) do_step(1'b0, 1'b0, "R4 down to zero");

        // R5 ASK shaping
        shape_mode = 2'b01; max_idx = 3'd7;
        do_step(1'b1, 1'b1, "R5 ask up");
        do_step(1'b1, 1'b1, "R5 ask up");
        do_step(1'b1, 1'b1, "R5 ask up");
        do_step(1'b1, 1'b0, "R5 ask down");
        do_step(1'b1, 1'b1, "R5 ask up");
        for (int i = 0; i < 5; i++) do_step(1'b1, 1'b0, "R5 ask down sat");
        do_step(1'b1, 1'b1, "R5 ask up");

        // R7 OOK
        shape_mode = 2'b10;
        do_step(1'b1, 1'b1, "R7 ook one");
        do_step(1'b1, 1'b0, "R7 ook zero");
        do_step(1'b1, 1'b1, "R7 ook one");
        do_step(1'b0, 1'b1, "R7 ook idle");

        // R8 write in the step cycle
        shape_mode = 2'b00; max_idx = 3'd3;
        for (int i = 0; i < 4; i++) do_step(1'b1, 1'b0, "R8 ramp to 3");
        do_step(1'b1, 1'b0, "R8 same-cycle write old word", 1, 3, 8'hC3);
        do_step(1'b1, 1'b0, "R8 new word next step");
        for (int i = 0; i < 4; i++) do_step(1'b0, 1'b0, "R8 ramp down");

        // R9 sleep entry with a competing write to entry 2
        @(negedge clk);
        sleep = 1'b1; tbl_wr_en = 1'b1; tbl_wr_idx = 3'd2; tbl_wr_data = 8'h77;
        for (int i = 1; i < 8; i++) m_tbl[i] = 8'h00;
        @(negedge clk);
        tbl_wr_en = 1'b0;
        @(negedge clk);
        sleep = 1'b0;
        shape_mode = 2'b10;
        do_step(1'b1, 1'b1, "R9 entry1 cleared");
        do_step(1'b1, 1'b0, "R9 entry0 kept");
        shape_mode = 2'b00; max_idx = 3'd7;
        for (int i = 0; i < 7; i++) do_step(1'b1, 1'b0, "R9 entries cleared");
        for (int i = 0; i < 8; i++) do_step(1'b0, 1'b0, "R9 down to entry0");

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule